// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous memory array uses during a four-beat burst. When a new access starts, a full external address is registered. On each later clock edge where the advance input is asserted, a small beat counter moves forward. The low address bits then follow either a linear order or an interleaved order, while the upper bits stay as they were loaded.

Two active-low strobes can start an access. The controller strobe always loads. The processor strobe loads only while the active-low chip enable is asserted. If advance is deasserted, the address is frozen and the burst is suspended. After the last beat the sequence wraps back to the starting address.

The order-select input picks the order:

- Order-select high gives the interleaved order: the low bits are the start XOR the beat number.
- Order-select low gives the linear order: the low bits are the start plus the beat number, modulo the burst length.

Order-select is a static strap. It should not change while bursts are in flight.

The block has no data stream, so every pin is a plain control or address signal. There is no valid/ready handshake and no back-pressure. The output address is combinational from two registers: the loaded address and the beat count. It therefore reflects a load or a step right after the clock edge that performed it.

Top module: `burst_addr_seq`

## Requirements
- R1: When ld_ctrl_n is low at a rising edge, word_addr equals the ext_addr sampled at that edge, whatever chip_en_n is.
- R2: ld_proc_n low loads ext_addr only when chip_en_n is also low. With chip_en_n high, the processor strobe has no effect on word_addr.
- R3: With both strobes inactive (high, or the processor strobe gated off) and adv_n low, the beat count rises by one per rising edge.
- R4: With both strobes inactive and adv_n high, word_addr holds its value.
- R5: With order_sel = 1 (interleaved), the low BURST_BITS bits of word_addr equal start XOR beat.
- R6: With order_sel = 0 (linear), the low BURST_BITS bits of word_addr equal (start + beat) mod 2^BURST_BITS.
- R7: After 2^BURST_BITS advances the address returns to the starting address, and the sequence repeats.
- R8: Bits ADDR_W-1 down to BURST_BITS of word_addr stay at the loaded value for the whole burst.
- R9: A synchronous active-high rst clears the loaded address and the beat count, so word_addr reads zero.
- R10: A load in the same cycle as an asserted advance takes the load, and the burst restarts at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_addr | input | ADDR_W | External start address |
| ld_proc_n | input | 1 | Processor load strobe, active low, gated by chip_en_n |
| ld_ctrl_n | input | 1 | Controller load strobe, active low, ungated |
| chip_en_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | 1 = interleaved order, 0 = linear order (static) |
| word_addr | output | ADDR_W | Current internal word address |

## Verification
The bench builds the block with ADDR_W = 6 and BURST_BITS = 2. This gives 64 possible start addresses, so every start address can be loaded in both orders and walked through more than a full wrap. Within those bursts, suspend cycles are mixed in.

The small address also makes every combination of the two strobes, chip enable and advance cheap to reach. The bench covers the gated processor load and loads that collide with an advance. Expected addresses are computed from the start value and a beat count kept in the bench.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } burst_order_e;

  typedef struct packed {
    logic load;
    logic step;
  } seq_cmd_t;

endpackage

// File: rtl/burst_strobe_dec.sv
module burst_strobe_dec
  import burst_seq_pkg::*;
(
  input  logic     ld_proc_n,
  input  logic     ld_ctrl_n,
  input  logic     chip_en_n,
  input  logic     adv_n,
  output seq_cmd_t cmd
);
  logic proc_hit;
  logic ctrl_hit;

  // The processor strobe only counts while the chip is enabled.
  always_comb begin
    proc_hit = ~ld_proc_n & ~chip_en_n;
    ctrl_hit = ~ld_ctrl_n;
  end

  // A load always wins over an advance.
  always_comb begin
    cmd.load = proc_hit | ctrl_hit;
    cmd.step = ~cmd.load & ~adv_n;
  end
endmodule

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BURST_BITS = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic                  step,
  output logic [BURST_BITS-1:0] beat
);
  localparam logic [BURST_BITS-1:0] ONE = BURST_BITS'(1);

  // Counts modulo 2^BURST_BITS, so wrap-around is natural.
  always_ff @(posedge clk) begin
    if (rst)       beat <= '0;
    else if (load) beat <= '0;
    else if (step) beat <= beat + ONE;
  end
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ext_addr,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (rst)       base <= '0;
    else if (load) base <= ext_addr;
  end
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2
) (
  input  logic [ADDR_W-1:0]     base,
  input  logic [BURST_BITS-1:0] beat,
  input  logic                  order_sel,
  output logic [ADDR_W-1:0]     word_addr
);
  localparam int HI_W = ADDR_W - BURST_BITS;

  logic [BURST_BITS-1:0] start_lo;
  logic [BURST_BITS-1:0] lin_lo;
  logic [BURST_BITS-1:0] xor_lo;
  logic [BURST_BITS-1:0] sel_lo;
  burst_order_e          mode;

  assign start_lo = base[BURST_BITS-1:0];
  assign mode     = burst_order_e'(order_sel);

  // Linear order: add the beat number to the start, modulo the burst length.
  assign lin_lo = start_lo + beat;

  // Interleaved order: flip each start bit where the beat number has a one.
  for (genvar i = 0; i < BURST_BITS; i++) begin : g_xor
    assign xor_lo[i] = start_lo[i] ^ beat[i];
  end

  always_comb begin
    unique case (mode)
      ORD_XOR:    sel_lo = xor_lo;
      ORD_LINEAR: sel_lo = lin_lo;
      default:    sel_lo = lin_lo;
    endcase
  end

  assign word_addr = {base[ADDR_W-1 -: HI_W], sel_lo};
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] ext_addr,
  input  logic              ld_proc_n,
  input  logic              ld_ctrl_n,
  input  logic              chip_en_n,
  input  logic              adv_n,
  input  logic              order_sel,
  output logic [ADDR_W-1:0] word_addr
);
  seq_cmd_t              cmd;
  logic [ADDR_W-1:0]     base;
  logic [BURST_BITS-1:0] beat;

  burst_strobe_dec u_dec (
    .ld_proc_n (ld_proc_n),
    .ld_ctrl_n (ld_ctrl_n),
    .chip_en_n (chip_en_n),
    .adv_n     (adv_n),
    .cmd       (cmd)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk      (clk),
    .rst      (rst),
    .load     (cmd.load),
    .ext_addr (ext_addr),
    .base     (base)
  );

  burst_beat_ctr #(.BURST_BITS(BURST_BITS)) u_ctr (
    .clk  (clk),
    .rst  (rst),
    .load (cmd.load),
    .step (cmd.step),
    .beat (beat)
  );

  burst_order_map #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_map (
    .base      (base),
    .beat      (beat),
    .order_sel (order_sel),
    .word_addr (word_addr)
  );
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W     = 18,
  parameter int BURST_BITS = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] ext_addr,
  input logic              ld_proc_n,
  input logic              ld_ctrl_n,
  input logic              chip_en_n,
  input logic              adv_n,
  input logic              order_sel,
  input logic [ADDR_W-1:0] word_addr
);
  logic any_load;
  logic idle;

  assign any_load = ~ld_ctrl_n | (~ld_proc_n & ~chip_en_n);
  assign idle     = ~any_load;

  p_ctrl_load_r1: assert property (@(posedge clk) disable iff (rst)
    !ld_ctrl_n |=> word_addr == $past(ext_addr));

  p_proc_gated_r2: assert property (@(posedge clk) disable iff (rst)
    (ld_ctrl_n && !ld_proc_n && chip_en_n && adv_n) |=> $stable(word_addr));

  p_step_lsb_r3: assert property (@(posedge clk) disable iff (rst)
    (idle && !adv_n) |=> word_addr[0] != $past(word_addr[0]));

  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (idle && adv_n) |=> $stable(word_addr));

  p_linear_r6: assert property (@(posedge clk) disable iff (rst)
    (idle && !adv_n && !order_sel) |=>
      (order_sel || word_addr[BURST_BITS-1:0] == $past(word_addr[BURST_BITS-1:0]) + 1'b1));

  p_upper_fixed_r8: assert property (@(posedge clk) disable iff (rst)
    idle |=> $stable(word_addr[ADDR_W-1:BURST_BITS]));

  p_reset_zero_r9: assert property (@(posedge clk)
    rst |=> word_addr == '0);

  p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (any_load && !adv_n) |=> word_addr == $past(ext_addr));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_BITS(BURST_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ext_addr  (ext_addr),
  .ld_proc_n (ld_proc_n),
  .ld_ctrl_n (ld_ctrl_n),
  .chip_en_n (chip_en_n),
  .adv_n     (adv_n),
  .order_sel (order_sel),
  .word_addr (word_addr)
);

// File: tb/burst_addr_seq_test.sv
`timescale 1ns/1ps
module burst_addr_seq_test;
  localparam int AW = 6;
  localparam int BB = 2;
  localparam int NB = 1 << BB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] ext_addr = '0;
  logic          ld_proc_n = 1'b1;
  logic          ld_ctrl_n = 1'b1;
  logic          chip_en_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          order_sel = 1'b0;
  logic [AW-1:0] word_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  int m_base = 0;
  int m_beat = 0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_BITS(BB)) uut (
    .clk(clk), .rst(rst), .ext_addr(ext_addr), .ld_proc_n(ld_proc_n),
    .ld_ctrl_n(ld_ctrl_n), .chip_en_n(chip_en_n), .adv_n(adv_n),
    .order_sel(order_sel), .word_addr(word_addr)
  );

  // Expected address from the requirements: upper bits kept, low bits ordered.
  function automatic int expect_addr();
    int lo;
    lo = m_base % NB;
    if (order_sel) lo = lo ^ m_beat;
    else           lo = (lo + m_beat) % NB;
    return (m_base / NB) * NB + lo;
  endfunction

  task automatic check(string tag);
    int e;
    e = expect_addr();
    n_cmp++;
    if (int'(word_addr) != e) begin
      n_bad++;
      $display("FAIL %s: word_addr=%0d expected=%0d", tag, word_addr, e);
    end
  endtask

  // Drive at the falling edge, let the rising edge act, compare at the next falling edge.
  task automatic cyc(input int ea, input bit pn, input bit cn, input bit en,
                     input bit av, input string tag);
    ext_addr = AW'(ea); ld_proc_n = pn; ld_ctrl_n = cn; chip_en_n = en; adv_n = av;
    @(posedge clk);
    if (rst) begin m_base = 0; m_beat = 0; end
    else if (!cn || (!pn && !en)) begin m_base = ea; m_beat = 0; end
    else if (!av) m_beat = (m_beat + 1) % NB;
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    @(negedge clk);
    cyc(45, 1, 1, 1, 0, "R9 reset");
    cyc(45, 1, 0, 0, 0, "R9 reset overrides load");
    rst = 1'b0;

    // Full sweep over every start address in both orders.
    for (int ord = 0; ord < 2; ord++) begin
      order_sel = ord[0];
      for (int a = 0; a < (1 << AW); a++) begin
        // R1: controller strobe loads even with chip enable high.
        cyc(a, 1, 0, a[0], 1, "R1 ctrl load");
        for (int b = 0; b < NB + 1; b++) begin
          cyc((a + 17) % 64, 1, 1, 0, 0, ord ? "R3/R5/R7/R8 interleaved beat" : "R3/R6/R7/R8 linear beat");
          if (b == 1) cyc((a + 5) % 64, 1, 1, 0, 1, "R4 suspend");
        end
      end
    end

    // R2: processor strobe with chip enable low loads.
    order_sel = 1'b0;
    cyc(22, 0, 1, 0, 1, "R2 proc load enabled");
    cyc(9, 1, 1, 0, 0, "R3 step after proc load");
    // R2: gated off with chip enable high, hold or step as if absent.
    cyc(50, 0, 1, 1, 1, "R2 proc ignored hold");
    cyc(50, 0, 1, 1, 0, "R2 proc ignored step");
    cyc(50, 0, 1, 1, 0, "R2 proc ignored step wrap");
    // R10: load in same cycle as advance restarts at beat 0.
    cyc(38, 1, 0, 1, 0, "R10 ctrl load with advance");
    cyc(38, 1, 1, 1, 0, "R10 step after load");
    cyc(11, 0, 1, 0, 0, "R10 proc load with advance");
    cyc(0, 1, 1, 1, 0, "R10 step after proc load");
    // R9: reset mid-burst.
    rst = 1'b1;
    cyc(63, 1, 1, 0, 0, "R9 reset mid burst");
    rst = 1'b0;
    cyc(63, 1, 1, 0, 0, "R9 step from cleared state");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule